// File: doc/BRIEF.md
# Multi-Grain Thread Priority Scorer

This block gives each hardware thread that shares a DRAM channel a priority score, refreshed every DRAM cycle, for a read scheduler to rank its pending reads. Each score has two parts that are added together. The slow part comes from sorting threads into two groups at the end of every long quantum. Threads that issue few reads are called latency-sensitive and all receive one fixed top value. Threads that issue many reads are called bandwidth-sensitive and receive distinct low ranks, and the order of those ranks rotates at a short interval so that no heavy thread stays last for long.

The fast part follows short-term behaviour. Each cycle the threads are ranked by how many reads each has waiting in the read queue, and the thread with the fewest waiting reads gets the largest bonus. The block also reports which thread currently has the highest total score. The quantum and shuffle lengths are parameters, so a test build can use short ones.

Top module: `mgps_prio_scorer`

## Requirements
- R1: During and after reset, `lat_mask` is all ones, every clustering score equals the latency value 2*NUM_THREADS (16 by default), the LFSR holds its seed, and `best_thread` is 0. With all waiting counts equal, every total score is therefore 16.
- R2: The density score of a thread is DENS_STEP (4) times the number of distinct waiting-count values that are strictly larger than its own. The thread with the largest count gets 0, and threads with equal counts get the same score. It appears in `score` one clock after `wait_cnt` is sampled.
- R3: Each `score` field (6 bits, thread i at bits [6i+5:6i]) holds the thread's clustering score plus its density score.
- R4: At the last cycle of each quantum (QUANTUM_CYC cycles from reset release), bit i of `lat_mask` becomes 1 when two conditions both hold. The thread's read count for that quantum must be at or below `lat_thresh`. Its cumulative read count times NUM_THREADS must also be at most twice the sum of all cumulative counts. Reads issued in that last cycle are included. `lat_mask` changes at no other cycle.
- R5: Cumulative read counts persist across quanta, so a thread whose cumulative share is too large stays bandwidth-sensitive even when it issued no reads in the last quantum.
- R6: A latency-sensitive thread has clustering score 2*NUM_THREADS. The K bandwidth-sensitive threads take the clustering scores 0..K-1, each exactly once. At a quantum boundary the rotation is 0, so these scores go in ascending thread-index order.
- R7: Every SHUFFLE_CYC cycles the bandwidth rank order rotates by one or two positions, modulo K. The step is 1 plus bit 0 of an 8-bit LFSR (feedback = XOR of bits 7,5,4,3; seed 1; it shifts every cycle). A quantum boundary falling on the same cycle resets the rotation to 0 instead.
- R8: `best_thread` is the index of the highest total score and is registered together with `score`. On ties the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_issue | input | NUM_THREADS | One pulse per read issued by thread i |
| wait_cnt | input | NUM_THREADS*WAIT_W | Reads waiting per thread, thread i at [WAIT_W*i +: WAIT_W] |
| lat_thresh | input | QCNT_W | Quantum read-count limit for the latency cluster |
| score | output | NUM_THREADS*SCORE_W | Registered total score per thread |
| best_thread | output | IDX_W | Index of the highest total score |
| lat_mask | output | NUM_THREADS | Current latency-cluster membership |

## Verification
The quantum boundary and the shuffle tick fall on the same cycle, because the test quantum is a multiple of the shuffle interval. In that case the rotation reset must win. The bench checks this by sampling the bandwidth scores a few cycles after each membership change and expecting exact ascending ranks, then sampling again one interval later and expecting a different arrangement of the same set. The density table is also applied while reads are still being counted for the first quantum. This checks that activity in one part has no effect on the scores of the other before the boundary.

// File: rtl/mgps_pkg.sv
package mgps_pkg;

  localparam int            LFSR_W    = 8;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

  // one shift of the free-running shuffle LFSR
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
  endfunction

  // reduce v into [0,m) assuming v < 3*m; zero when m is zero
  function automatic int unsigned wrap_mod(input int unsigned v, input int unsigned m);
    int unsigned r;
    r = v;
    if (m == 0) return 0;
    if (r >= m) r = r - m;
    if (r >= m) r = r - m;
    return r;
  endfunction

endpackage

// File: rtl/mgps_read_tracker.sv
module mgps_read_tracker #(
  parameter int NUM_THREADS = 8,
  parameter int QCNT_W      = 20,
  parameter int CUM_W       = 64,
  parameter int QUANTUM_CYC = 1000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] rd_issue,
  input  logic [QCNT_W-1:0]      lat_thresh,
  output logic [NUM_THREADS-1:0] lat_mask,
  output logic                   q_tick
);
  localparam int QT_W  = $clog2(QUANTUM_CYC);
  localparam int SUM_W = CUM_W + $clog2(NUM_THREADS) + 2;
  localparam logic [QCNT_W-1:0] QMAX = '1;

  logic [QT_W-1:0]   qtimer;
  logic [QCNT_W-1:0] q_cnt   [NUM_THREADS];
  logic [CUM_W-1:0]  cum_cnt [NUM_THREADS];
  logic [QCNT_W-1:0] q_fin   [NUM_THREADS];
  logic [CUM_W-1:0]  cum_fin [NUM_THREADS];
  logic [SUM_W-1:0]  cum_sum;
  logic [NUM_THREADS-1:0] lat_next;

  assign q_tick = (qtimer == QT_W'(QUANTUM_CYC - 1));

  always_comb begin
    cum_sum = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      q_fin[i]   = (q_cnt[i] == QMAX) ? QMAX : q_cnt[i] + QCNT_W'(rd_issue[i]);
      cum_fin[i] = cum_cnt[i] + CUM_W'(rd_issue[i]);
      cum_sum    = cum_sum + SUM_W'(cum_fin[i]);
    end
    for (int i = 0; i < NUM_THREADS; i++) begin
      lat_next[i] = (q_fin[i] <= lat_thresh) &&
                    ((SUM_W'(cum_fin[i]) * SUM_W'(NUM_THREADS)) <= (cum_sum << 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtimer   <= '0;
      lat_mask <= '1;
      for (int i = 0; i < NUM_THREADS; i++) begin
        q_cnt[i]   <= '0;
        cum_cnt[i] <= '0;
      end
    end else begin
      qtimer <= q_tick ? '0 : qtimer + 1'b1;
      for (int i = 0; i < NUM_THREADS; i++) begin
        q_cnt[i]   <= q_tick ? '0 : q_fin[i];
        cum_cnt[i] <= cum_fin[i];
      end
      if (q_tick) lat_mask <= lat_next;
    end
  end

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_tick |=> $stable(lat_mask));

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    // R4
    qcnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_tick && q_cnt[g] == QMAX) |=> (q_cnt[g] == QMAX));
    // R5
    cum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_tick |=> (cum_cnt[g] >= $past(cum_cnt[g])));
  end

endmodule

// File: rtl/mgps_shuffle.sv
module mgps_shuffle #(
  parameter int NUM_THREADS = 8,
  parameter int SHUFFLE_CYC = 1024,
  localparam int IDX_W = $clog2(NUM_THREADS),
  localparam int CNT_W = $clog2(NUM_THREADS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_tick,
  input  logic [CNT_W-1:0] nbw,
  output logic [IDX_W-1:0] rot
);
  import mgps_pkg::*;
  localparam int ST_W = $clog2(SHUFFLE_CYC);

  logic [ST_W-1:0]   stimer;
  logic [LFSR_W-1:0] lfsr;
  logic              shuf_tick;
  logic [IDX_W-1:0]  rot_next;

  assign shuf_tick = (stimer == ST_W'(SHUFFLE_CYC - 1));
  assign rot_next  = IDX_W'(wrap_mod(32'(rot) + 32'(lfsr[0]) + 32'd1, 32'(nbw)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stimer <= '0;
      lfsr   <= LFSR_SEED;
      rot    <= '0;
    end else begin
      stimer <= shuf_tick ? '0 : stimer + 1'b1;
      lfsr   <= lfsr_step(lfsr);
      if (q_tick)         rot <= '0;
      else if (shuf_tick) rot <= rot_next;
    end
  end

  // R7
  rot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nbw != 0) |-> (CNT_W'(rot) < nbw));
  // R7
  rot_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shuf_tick && !q_tick && nbw >= 3) |=> (rot != $past(rot)));
  // R7
  rot_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_tick |=> (rot == '0));

endmodule

// File: rtl/mgps_density.sv
module mgps_density #(
  parameter int NUM_THREADS = 8,
  parameter int WAIT_W      = 6,
  parameter int DENS_STEP   = 4,
  parameter int DSC_W       = 5
) (
  input  logic [NUM_THREADS*WAIT_W-1:0] wait_cnt,
  output logic [NUM_THREADS*DSC_W-1:0]  dens
);
  localparam int CNT_W = $clog2(NUM_THREADS + 1);

  logic [WAIT_W-1:0] w [NUM_THREADS];
  logic [NUM_THREADS-1:0] first_of_val;

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) w[i] = wait_cnt[i*WAIT_W +: WAIT_W];
    // a thread stands for its value only if no lower index carries the same count
    for (int j = 0; j < NUM_THREADS; j++) begin
      first_of_val[j] = 1'b1;
      for (int k = 0; k < j; k++)
        if (w[k] == w[j]) first_of_val[j] = 1'b0;
    end
  end

  always_comb begin
    logic [CNT_W-1:0] rank;
    dens = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      rank = '0;
      for (int j = 0; j < NUM_THREADS; j++)
        if (first_of_val[j] && (w[j] > w[i])) rank = rank + 1'b1;
      dens[i*DSC_W +: DSC_W] = DSC_W'(32'(rank) * DENS_STEP);
    end
  end

endmodule

// File: rtl/mgps_cluster_rank.sv
module mgps_cluster_rank #(
  parameter int NUM_THREADS = 8,
  parameter int LAT_SCORE   = 16,
  parameter int CSC_W       = 5,
  localparam int IDX_W = $clog2(NUM_THREADS),
  localparam int CNT_W = $clog2(NUM_THREADS + 1)
) (
  input  logic [NUM_THREADS-1:0]       lat_mask,
  input  logic [IDX_W-1:0]             rot,
  output logic [NUM_THREADS*CSC_W-1:0] clus,
  output logic [CNT_W-1:0]             nbw
);
  import mgps_pkg::*;

  always_comb begin
    nbw = '0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (!lat_mask[i]) nbw = nbw + 1'b1;
  end

  always_comb begin
    int unsigned pos;
    pos  = 0;
    clus = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (lat_mask[i]) begin
        clus[i*CSC_W +: CSC_W] = CSC_W'(LAT_SCORE);
      end else begin
        clus[i*CSC_W +: CSC_W] = CSC_W'(wrap_mod(pos + 32'(rot), 32'(nbw)));
        pos = pos + 1;
      end
    end
  end

endmodule

// File: rtl/mgps_prio_scorer.sv
module mgps_prio_scorer #(
  parameter int NUM_THREADS = 8,
  parameter int WAIT_W      = 6,
  parameter int QCNT_W      = 20,
  parameter int CUM_W       = 64,
  parameter int QUANTUM_CYC = 1000000,
  parameter int SHUFFLE_CYC = 1024,
  parameter int DENS_STEP   = 4,
  localparam int IDX_W     = $clog2(NUM_THREADS),
  localparam int LAT_SCORE = 2 * NUM_THREADS,
  localparam int SCORE_W   = $clog2(LAT_SCORE + DENS_STEP * (NUM_THREADS - 1) + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        rd_issue,
  input  logic [NUM_THREADS*WAIT_W-1:0] wait_cnt,
  input  logic [QCNT_W-1:0]             lat_thresh,
  output logic [NUM_THREADS*SCORE_W-1:0] score,
  output logic [IDX_W-1:0]              best_thread,
  output logic [NUM_THREADS-1:0]        lat_mask
);
  localparam int CSC_W = $clog2(LAT_SCORE + 1);
  localparam int DSC_W = $clog2(DENS_STEP * (NUM_THREADS - 1) + 1);
  localparam int CNT_W = $clog2(NUM_THREADS + 1);

  logic                          q_tick;
  logic [CNT_W-1:0]              nbw;
  logic [IDX_W-1:0]              rot;
  logic [NUM_THREADS*CSC_W-1:0]  clus_flat;
  logic [NUM_THREADS*DSC_W-1:0]  dens_flat;
  logic [SCORE_W-1:0]            total [NUM_THREADS];
  logic [SCORE_W-1:0]            score_q [NUM_THREADS];
  logic [IDX_W-1:0]              best_n;

  mgps_read_tracker #(
    .NUM_THREADS(NUM_THREADS), .QCNT_W(QCNT_W), .CUM_W(CUM_W), .QUANTUM_CYC(QUANTUM_CYC)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .lat_thresh(lat_thresh),
    .lat_mask(lat_mask), .q_tick(q_tick)
  );

  mgps_shuffle #(.NUM_THREADS(NUM_THREADS), .SHUFFLE_CYC(SHUFFLE_CYC)) u_shuf (
    .clk(clk), .rst_n(rst_n), .q_tick(q_tick), .nbw(nbw), .rot(rot)
  );

  mgps_cluster_rank #(.NUM_THREADS(NUM_THREADS), .LAT_SCORE(LAT_SCORE), .CSC_W(CSC_W)) u_clus (
    .lat_mask(lat_mask), .rot(rot), .clus(clus_flat), .nbw(nbw)
  );

  mgps_density #(
    .NUM_THREADS(NUM_THREADS), .WAIT_W(WAIT_W), .DENS_STEP(DENS_STEP), .DSC_W(DSC_W)
  ) u_dens (
    .wait_cnt(wait_cnt), .dens(dens_flat)
  );

  always_comb begin
    logic [SCORE_W-1:0] best_v;
    for (int i = 0; i < NUM_THREADS; i++)
      total[i] = SCORE_W'(clus_flat[i*CSC_W +: CSC_W]) + SCORE_W'(dens_flat[i*DSC_W +: DSC_W]);
    best_n = '0;
    best_v = total[0];
    for (int i = 1; i < NUM_THREADS; i++)
      if (total[i] > best_v) begin
        best_v = total[i];
        best_n = IDX_W'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_thread <= '0;
      for (int i = 0; i < NUM_THREADS; i++) score_q[i] <= SCORE_W'(LAT_SCORE);
    end else begin
      best_thread <= best_n;
      for (int i = 0; i < NUM_THREADS; i++) score_q[i] <= total[i];
    end
  end

  always_comb
    for (int i = 0; i < NUM_THREADS; i++) score[i*SCORE_W +: SCORE_W] = score_q[i];

  // checker-side observations built from port-level state
  logic best_beaten;
  logic [NUM_THREADS-1:0] has_bigger_wait;
  always_comb begin
    best_beaten = 1'b0;
    for (int j = 0; j < NUM_THREADS; j++)
      if ((score_q[j] > score_q[best_thread]) ||
          ((score_q[j] == score_q[best_thread]) && (IDX_W'(j) < best_thread)))
        best_beaten = 1'b1;
    for (int i = 0; i < NUM_THREADS; i++) begin
      has_bigger_wait[i] = 1'b0;
      for (int j = 0; j < NUM_THREADS; j++)
        if (wait_cnt[j*WAIT_W +: WAIT_W] > wait_cnt[i*WAIT_W +: WAIT_W]) has_bigger_wait[i] = 1'b1;
    end
  end

  // R8
  best_max_chk: assert property (@(posedge clk) disable iff (!rst_n) !best_beaten);

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
    // R2
    dens_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dens_flat[g*DSC_W +: DSC_W] == '0) |-> !has_bigger_wait[g]);
    // R6
    lat_score_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_mask[g] |-> (clus_flat[g*CSC_W +: CSC_W] == CSC_W'(LAT_SCORE)));
    // R6
    bw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_mask[g] |-> (CNT_W'(clus_flat[g*CSC_W +: CSC_W]) < nbw));
  end

endmodule

// File: tb/tb_mgps_prio_scorer.sv
`timescale 1ns/1ps
module tb_mgps_prio_scorer;
  localparam int N  = 8;
  localparam int WW = 6;
  localparam int SW = 6;
  localparam int QC = 64;
  localparam int SC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rd_issue = '0;
  logic [N*WW-1:0] wait_cnt = '0;
  logic [19:0] lat_thresh = 20'd4;
  logic [N*SW-1:0] score;
  logic [2:0] best_thread;
  logic [N-1:0] lat_mask;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mgps_prio_scorer #(.NUM_THREADS(N), .WAIT_W(WW), .QUANTUM_CYC(QC), .SHUFFLE_CYC(SC)) dut (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .wait_cnt(wait_cnt),
    .lat_thresh(lat_thresh), .score(score), .best_thread(best_thread), .lat_mask(lat_mask)
  );

  typedef struct packed {
    logic [N*WW-1:0] waits;
    logic [N*SW-1:0] exp;
    logic [2:0]      best;
  } vec_t;

  // thread 7 leftmost; quantum 0 so every clustering score is 16
  localparam vec_t VECS [6] = '{
    '{ {6'd4,6'd3,6'd1,6'd7,6'd2,6'd5,6'd4,6'd6}, {6'd28,6'd32,6'd40,6'd16,6'd36,6'd24,6'd28,6'd20}, 3'd5 },
    '{ {6'd5,6'd5,6'd5,6'd5,6'd5,6'd5,6'd5,6'd5}, {6'd16,6'd16,6'd16,6'd16,6'd16,6'd16,6'd16,6'd16}, 3'd0 },
    '{ {6'd0,6'd1,6'd2,6'd3,6'd4,6'd5,6'd6,6'd7}, {6'd44,6'd40,6'd36,6'd32,6'd28,6'd24,6'd20,6'd16}, 3'd7 },
    '{ {6'd0,6'd0,6'd9,6'd0,6'd0,6'd9,6'd9,6'd0}, {6'd20,6'd20,6'd16,6'd20,6'd20,6'd16,6'd16,6'd20}, 3'd0 },
    '{ {6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd63}, {6'd20,6'd20,6'd20,6'd20,6'd20,6'd20,6'd20,6'd16}, 3'd1 },
    '{ {6'd0,6'd0,6'd2,6'd2,6'd1,6'd1,6'd3,6'd3}, {6'd28,6'd28,6'd20,6'd20,6'd24,6'd24,6'd16,6'd16}, 3'd6 }
  };

  function automatic int sc(input int i);
    return int'(score[i*SW +: SW]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_mask_change(input logic [N-1:0] old);
    int n = 0;
    while (lat_mask == old && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (n >= 300) check("R4 mask change timeout", 0, 1);
  endtask

  task automatic drive_reads();
    for (int k = 0; k < 30; k++) begin
      logic [N-1:0] p;
      p = '0;
      p[6] = 1'b1; p[7] = 1'b1;
      if (k < 10) begin p[4] = 1'b1; p[5] = 1'b1; end
      if (k < 5) p[1] = 1'b1;
      if (k < 4) p[3] = 1'b1;
      if (k < 3) p[2] = 1'b1;
      rd_issue = p;
      @(negedge clk);
    end
    rd_issue = '0;
  endtask

  task automatic run_table();
    foreach (VECS[v]) begin
      wait_cnt = VECS[v].waits;
      @(negedge clk);
      for (int i = 0; i < N; i++)
        check($sformatf("R2/R3 vec%0d thr%0d", v, i), sc(i), int'(VECS[v].exp[i*SW +: SW]));
      check($sformatf("R8 vec%0d best", v), int'(best_thread), int'(VECS[v].best));
    end
    wait_cnt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a_t1;
    int seen [N];
    int bw_ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mask", int'(lat_mask), 255);
    check("R1 best", int'(best_thread), 0);
    for (int i = 0; i < N; i++) check("R1 score", sc(i), 16);
    rst_n = 1'b1;
    // reads counted for quantum 0 while density table runs
    fork
      drive_reads();
      run_table();
    join

    // R4 quantum 0 result: thr3 at thresh is latency, thr1 just above is not
    wait_mask_change(8'hFF);
    check("R4 mask after q0", int'(lat_mask), 8'h0D);
    repeat (4) @(negedge clk);
    // R6 rotation reset at boundary: bw threads 1,4,5,6,7 ranks 0..4
    check("R6 thr0", sc(0), 16);
    check("R6 thr1", sc(1), 0);
    check("R6 thr2", sc(2), 16);
    check("R6 thr3", sc(3), 16);
    check("R6 thr4", sc(4), 1);
    check("R6 thr5", sc(5), 2);
    check("R6 thr6", sc(6), 3);
    check("R6 thr7", sc(7), 4);
    check("R8 best tie", int'(best_thread), 0);
    // R3 sum of cluster and density: waits thread i = 7-i
    wait_cnt = {6'd0,6'd1,6'd2,6'd3,6'd4,6'd5,6'd6,6'd7};
    @(negedge clk);
    check("R3 thr0", sc(0), 16);
    check("R3 thr1", sc(1), 4);
    check("R3 thr2", sc(2), 24);
    check("R3 thr3", sc(3), 28);
    check("R3 thr4", sc(4), 17);
    check("R3 thr5", sc(5), 22);
    check("R3 thr6", sc(6), 27);
    check("R3 thr7", sc(7), 32);
    check("R8 best sum", int'(best_thread), 7);
    wait_cnt = '0;
    a_t1 = 0;
    repeat (15) @(negedge clk);
    // R7 one shuffle tick later: same rank set, order moved
    for (int i = 0; i < N; i++) seen[i] = 0;
    bw_ok = 1;
    for (int i = 0; i < N; i++) begin
      if (lat_mask[i]) check("R7 lat kept", sc(i), 16);
      else if (sc(i) < 5) seen[sc(i)]++;
      else bw_ok = 0;
    end
    for (int r = 0; r < 5; r++) if (seen[r] != 1) bw_ok = 0;
    check("R7 bw ranks permutation", bw_ok, 1);
    check("R7 rotation moved", int'(sc(1) != a_t1), 1);

    // R5 quantum 1 had no reads; heavy cumulative share keeps thr6/7 bandwidth
    wait_mask_change(8'h0D);
    check("R5 mask after q1", int'(lat_mask), 8'h3F);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) check("R5 lat score", sc(i), 16);
    check("R5 thr6", sc(6), 0);
    check("R5 thr7", sc(7), 1);
    check("R8 best q1", int'(best_thread), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule